// File: doc/BRIEF.md
# Two-Stage Expiry Watchdog Timer

This block is a watchdog peripheral on a plain 32-bit register port. A timebase counter runs on every clock from reset and can be read at any time. A separate interval counter runs only while the watchdog is armed. Each time that counter wraps after 2^N cycles it is an expiry. The first expiry that finds the warning flag clear sets the flag and sends a one-cycle interrupt to software. An expiry that finds the flag still set sends a one-cycle reset request to the system and sets a sticky reset-cause flag.

Software keeps the system alive by writing 1 to the warning flag before the next expiry. The watchdog has two enable bits, held in two different word registers. It runs while either bit is set. The first enable bit cannot be cleared on its own while the second is still set. Because of this, a single stray write cannot stop the watchdog.

Top module: `twostage_wdog`

## Requirements
- R1: Byte offset 0x0 selects control word A, 0x4 selects control word B and 0x8 selects the timebase. Any other offset, including one with address bits [1:0] non-zero, reads as zero. Writes to the timebase or to unmapped offsets change nothing. A read returns data combinationally in the same cycle as its address.
- R2: The timebase is 32 bits wide. It is zero while reset is held and then advances by one on every clock, whether or not the watchdog is armed. Two reads on consecutive cycles differ by exactly one.
- R3: Control word A reads as {28'b0, cause[3], warn[2], arm_a[1], arm_b[0]}, where bit 0 is a read-only copy of arm_b. Control word B reads as {31'b0, arm_b[0]}, and a write to B sets arm_b from bit 0 and ignores every other bit.
- R4: Writing word A with bit 1 = 1 sets arm_a. Writing word A with bit 1 = 0 clears arm_a at once if arm_b is clear. If arm_b is set, the clear is not applied then; it is held pending, and both enables clear on the next write of word B with bit 0 = 0.
- R5: The interval counter holds at zero while arm_a and arm_b are both clear. When armed, the first expiry happens 2^N clock edges after the edge that stored the enable. After that, expiries recur every 2^N edges.
- R6: An expiry with warn clear sets warn and drives `irq` high for exactly the one cycle after the expiry edge.
- R7: While warn stays set, later expiries do not pulse `irq` again.
- R8: An expiry with warn already set drives `wdt_rst` high for exactly one cycle, sets cause, and leaves warn set. This happens 2^(N+1) edges after arming if software never services the watchdog.
- R9: Writing 1 to bit 3 or bit 2 of word A clears cause or warn. Writing 0 to either bit leaves it unchanged. An expiry on the same edge as the clear wins over the clear.
- R10: Servicing the watchdog (writing 1 to bit 2) between the two expiries makes the next expiry raise `irq` again instead of `wdt_rst`.
- R11: Synchronous active-low reset clears every register. After reset both control words read zero, and `irq` and `wdt_rst` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe; the write takes effect on this clock edge |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, valid in the same cycle |
| irq | output | 1 | One-cycle warning pulse on the first unserviced expiry |
| wdt_rst | output | 1 | One-cycle reset request on the second unserviced expiry |

## Verification
Read data depends only on the address and the registered state. The bench therefore samples `rdata` 1 ns after it drives the address on a falling edge, and samples register effects on the falling edge after the write's rising edge. Expiry results come one register after the expiry edge. The bench counts rising edges from the edge that stored the enable and expects `irq` at exactly 2^N and `wdt_rst` at exactly 2^(N+1). It observes both outputs on falling edges, so that each one-cycle pulse is seen exactly once. For the clear-versus-expiry race, the bench times a service write to land on edge 2^N itself.

// File: rtl/twostage_wdog_pkg.sv
// Package: shared register offsets, bit positions and the address decoder
// for the two-stage watchdog. Assumes byte addressing with 32-bit words.
package twostage_wdog_pkg;

    localparam int unsigned OFS_CTRL_A = 32'h0;
    localparam int unsigned OFS_CTRL_B = 32'h4;
    localparam int unsigned OFS_TICK   = 32'h8;

    localparam int BIT_CAUSE = 3;
    localparam int BIT_WARN  = 2;
    localparam int BIT_ARM_A = 1;
    localparam int BIT_ARM_B = 0;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL_A,
        SEL_CTRL_B,
        SEL_TICK
    } reg_sel_e;

    // Map a zero-extended byte address to a register select.
    function automatic reg_sel_e decode_addr(input logic [31:0] byte_addr);
        reg_sel_e sel;
        case (byte_addr)
            OFS_CTRL_A: sel = SEL_CTRL_A;
            OFS_CTRL_B: sel = SEL_CTRL_B;
            OFS_TICK:   sel = SEL_TICK;
            default:    sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/wd_timebase.sv
// Free-running timebase counter.
// Does: counts every clock from zero after reset and wraps modulo 2^TB_W.
// Assumes: nothing gates it; it runs whether or not the watchdog is armed.
module wd_timebase #(
    parameter int TB_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TB_W-1:0] tick
);

    // Advance the timebase by one every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) tick <= '0;
        else        tick <= tick + TB_W'(1);
    end

endmodule

// File: rtl/wd_interval.sv
// Interval counter for the watchdog expiry.
// Does: counts while run is high, holds at zero while run is low, and flags
//       the cycle in which the count is about to wrap (an expiry).
// Assumes: IW >= 1; run comes from registered enables.
module wd_interval #(
    parameter int IW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam logic [IW-1:0] LAST = {IW{1'b1}};

    logic [IW-1:0] cnt;

    // Count while armed, clear to zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + IW'(1);
    end

    // The expiry is the wrap from the last count back to zero.
    assign expire = run && (cnt == LAST);

endmodule

// File: rtl/wd_expiry.sv
// Two-stage expiry logic.
// Does: the first expiry with warn clear sets warn and pulses irq; an expiry
//       with warn set pulses wdt_rst and sets the sticky cause flag.
// Assumes: clear requests come from write-one-to-clear decode; an expiry on
//          the same edge takes priority over a clear.
module wd_expiry (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_warn,
    input  logic clr_cause,
    output logic warn,
    output logic cause,
    output logic irq,
    output logic wdt_rst
);

    // Registered one-cycle pulses, chosen by the warn state at the expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            wdt_rst <= 1'b0;
        end else begin
            irq     <= expire && !warn;
            wdt_rst <= expire && warn;
        end
    end

    // Warn flag: set by any expiry, otherwise cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        warn <= 1'b0;
        else if (expire)   warn <= 1'b1;
        else if (clr_warn) warn <= 1'b0;
    end

    // Cause flag: set by a second-stage expiry, otherwise cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)              cause <= 1'b0;
        else if (expire && warn) cause <= 1'b1;
        else if (clr_cause)      cause <= 1'b0;
    end

endmodule

// File: rtl/wd_regs.sv
// Register port for the watchdog.
// Does: decodes writes to the two control words, keeps both enable bits and
//       the pending disable of arm_a, drives the clear requests and the read
//       mux.
// Assumes: ADDR_W <= 32, DATA_W >= 4; reads are combinational from addr.
module wd_regs
    import twostage_wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] tick,
    input  logic              warn,
    input  logic              cause,
    output logic              arm_a,
    output logic              arm_b,
    output logic              clr_warn,
    output logic              clr_cause,
    output logic [DATA_W-1:0] rdata
);

    reg_sel_e sel;
    logic     wr_a;
    logic     wr_b;
    logic     drop_pend;

    assign sel       = decode_addr(32'(addr));
    assign wr_a      = wr_en && (sel == SEL_CTRL_A);
    assign wr_b      = wr_en && (sel == SEL_CTRL_B);
    assign clr_warn  = wr_a && wdata[BIT_WARN];
    assign clr_cause = wr_a && wdata[BIT_CAUSE];

    // Enable bits: arm_a may only drop alone when arm_b is already clear,
    // otherwise the request waits for arm_b to be cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_a     <= 1'b0;
            arm_b     <= 1'b0;
            drop_pend <= 1'b0;
        end else begin
            if (wr_a) begin
                if (wdata[BIT_ARM_A]) begin
                    arm_a     <= 1'b1;
                    drop_pend <= 1'b0;
                end else if (!arm_b) begin
                    arm_a     <= 1'b0;
                end else begin
                    drop_pend <= 1'b1;
                end
            end
            if (wr_b) begin
                arm_b <= wdata[BIT_ARM_B];
                if (!wdata[BIT_ARM_B] && drop_pend) begin
                    arm_a     <= 1'b0;
                    drop_pend <= 1'b0;
                end
            end
        end
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL_A: begin
                rdata[BIT_CAUSE] = cause;
                rdata[BIT_WARN]  = warn;
                rdata[BIT_ARM_A] = arm_a;
                rdata[BIT_ARM_B] = arm_b;
            end
            SEL_CTRL_B: rdata[BIT_ARM_B] = arm_b;
            SEL_TICK:   rdata = tick;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/twostage_wdog.sv
// Two-stage watchdog top.
// Does: joins the timebase, interval counter, expiry logic and register
//       port; the watchdog runs while either enable bit is set.
// Assumes: INTERVAL_LOG2 >= 1; wdt_rst is not looped back to rst_n here.
module twostage_wdog #(
    parameter int INTERVAL_LOG2 = 16,
    parameter int ADDR_W        = 4,
    parameter int DATA_W        = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              wdt_rst
);

    logic [DATA_W-1:0] tick;
    logic              en1;
    logic              en2;
    logic              expire;
    logic              state_flag;
    logic              rst_flag;
    logic              clr_warn;
    logic              clr_cause;

    wd_timebase #(.TB_W(DATA_W)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    wd_interval #(.IW(INTERVAL_LOG2)) u_ivl (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (en1 | en2),
        .expire (expire)
    );

    wd_expiry u_exp (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .clr_warn  (clr_warn),
        .clr_cause (clr_cause),
        .warn      (state_flag),
        .cause     (rst_flag),
        .irq       (irq),
        .wdt_rst   (wdt_rst)
    );

    wd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .tick      (tick),
        .warn      (state_flag),
        .cause     (rst_flag),
        .arm_a     (en1),
        .arm_b     (en2),
        .clr_warn  (clr_warn),
        .clr_cause (clr_cause),
        .rdata     (rdata)
    );

endmodule

// File: rtl/twostage_wdog_chk.sv
// Checker for the two-stage watchdog, bound to every instance of the top.
// Does: temporal checks on pulses, flags, enables and the timebase.
// Assumes: reset is held for at least one clock at start.
module twostage_wdog_chk
    import twostage_wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic              wdt_rst,
    input logic              en1,
    input logic              en2,
    input logic              state_flag,
    input logic              rst_flag
);

    localparam logic [ADDR_W-1:0] A_CTRL_A = ADDR_W'(OFS_CTRL_A);
    localparam logic [ADDR_W-1:0] A_CTRL_B = ADDR_W'(OFS_CTRL_B);
    localparam logic [ADDR_W-1:0] A_TICK   = ADDR_W'(OFS_TICK);

    p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && addr == A_TICK && $past(addr) == A_TICK)
        |-> rdata == $past(rdata) + DATA_W'(1));

    p_en_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en1) && $past(en2)
         && !($past(wr_en) && $past(addr) == A_CTRL_B)) |-> en1);

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en1) && !$past(en2)) |-> (!irq && !wdt_rst));

    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_sets_warn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> state_flag);

    p_warn_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && irq) |-> !$past(state_flag));

    p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);

    p_rst_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && wdt_rst) |-> ($past(state_flag) && rst_flag && state_flag));

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && wdt_rst));

    p_cause_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_flag)
         && !($past(wr_en) && $past(addr) == A_CTRL_A && $past(wdata[BIT_CAUSE])))
        |-> rst_flag);

    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> (!irq && !wdt_rst && !en1 && !en2 && !state_flag && !rst_flag));

endmodule

bind twostage_wdog twostage_wdog_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .irq        (irq),
    .wdt_rst    (wdt_rst),
    .en1        (en1),
    .en2        (en2),
    .state_flag (state_flag),
    .rst_flag   (rst_flag)
);

// File: tb/twostage_wdog_test.sv
// Bench for the two-stage watchdog: a register vector table, then directed
// tests for expiry timing, servicing, clears, races and reset.
module twostage_wdog_test;

    localparam int N  = 6;
    localparam int IV = 1 << N;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;
    logic        wdt_rst;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int irq_seen = 0;
    int rst_seen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    twostage_wdog #(.INTERVAL_LOG2(N), .ADDR_W(4), .DATA_W(32)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq     (irq),
        .wdt_rst (wdt_rst)
    );

    // Rising-edge count and pulse counters seen on falling edges.
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (irq)     irq_seen <= irq_seen + 1;
        if (wdt_rst) rst_seen <= rst_seen + 1;
    end

    typedef struct packed {
        logic        wr;
        logic [3:0]  a;
        logic [31:0] d;
        logic [31:0] e;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'h0, 32'h0,        32'h0, 4'd11}, // R11 word A after reset
        '{1'b0, 4'h4, 32'h0,        32'h0, 4'd11}, // R11 word B after reset
        '{1'b0, 4'hC, 32'h0,        32'h0, 4'd1},  // R1 unmapped
        '{1'b0, 4'h2, 32'h0,        32'h0, 4'd1},  // R1 unaligned
        '{1'b1, 4'h4, 32'h1,        32'h0, 4'd3},
        '{1'b0, 4'h4, 32'h0,        32'h1, 4'd3},  // R3 arm_b in B
        '{1'b0, 4'h0, 32'h0,        32'h1, 4'd3},  // R3 copy in A bit 0
        '{1'b1, 4'h0, 32'h2,        32'h0, 4'd4},
        '{1'b0, 4'h0, 32'h0,        32'h3, 4'd4},  // R4 arm_a set
        '{1'b1, 4'h0, 32'h0,        32'h0, 4'd4},
        '{1'b0, 4'h0, 32'h0,        32'h3, 4'd4},  // R4 lone clear held
        '{1'b1, 4'h4, 32'h0,        32'h0, 4'd4},
        '{1'b0, 4'h0, 32'h0,        32'h0, 4'd4},  // R4 both cleared in order
        '{1'b0, 4'h4, 32'h0,        32'h0, 4'd4},
        '{1'b1, 4'h0, 32'h2,        32'h0, 4'd4},
        '{1'b0, 4'h0, 32'h0,        32'h2, 4'd4},
        '{1'b1, 4'h0, 32'h0,        32'h0, 4'd4},
        '{1'b0, 4'h0, 32'h0,        32'h0, 4'd4},  // R4 direct clear, arm_b clear
        '{1'b1, 4'h4, 32'hFFFFFFFE, 32'h0, 4'd3},
        '{1'b0, 4'h4, 32'h0,        32'h0, 4'd3}   // R3 only bit 0 of B writable
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr  = a;
        wr_en = 1'b0;
        #1;
        d = rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        wdata = '0;
    endtask

    task automatic wait_evt(input int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (irq || wdt_rst) break;
        end
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog on the run time.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v, a0, b0, c0;
        int e0, i0, r0;
        rst_n = 1'b0;
        wr_en = 1'b0;
        addr  = '0;
        wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(4'h8, v);
        chk("R11 timebase one edge after reset", v, 32'd1);
        chk("R11 irq low", {31'b0, irq}, 32'd0);
        chk("R11 wdt_rst low", {31'b0, wdt_rst}, 32'd0);

        // Register vector table.
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            if (VECS[k].wr) begin
                wr(VECS[k].a, VECS[k].d);
            end else begin
                rd(VECS[k].a, v);
                checks++;
                if (v !== VECS[k].e) begin
                    errors++;
                    $display("FAIL R%0d vector %0d actual=%h expected=%h",
                             VECS[k].req, k, v, VECS[k].e);
                end
            end
        end

        // R2 / R1: timebase steps by one; a write to it is ignored.
        @(negedge clk);
        rd(4'h8, a0);
        @(negedge clk);
        rd(4'h8, b0);
        chk("R2 consecutive timebase reads", b0, a0 + 32'd1);
        wr(4'h8, 32'hDEADBEEF);
        rd(4'h8, c0);
        chk("R1 timebase write ignored", c0, b0 + 32'd1);

        // R5..R9: arm with arm_b only, never service.
        wr(4'h4, 32'h1);
        e0 = cyc;
        i0 = irq_seen;
        wait_evt(3 * IV);
        chk("R5 first expiry edge", cyc - e0, IV);
        chk("R6 irq at first expiry", {31'b0, irq}, 32'd1);
        rd(4'h0, v);
        chk("R3 word A with warn and arm_b", v, 32'h5);
        @(negedge clk);
        chk("R6 irq one cycle", {31'b0, irq}, 32'd0);
        wait_evt(3 * IV);
        chk("R8 wdt_rst at second expiry", {31'b0, wdt_rst}, 32'd1);
        chk("R8 second expiry edge", cyc - e0, 2 * IV);
        chk("R7 no repeated irq", irq_seen - i0, 1);
        rd(4'h0, v);
        chk("R8 cause and warn set", v, 32'hD);
        @(negedge clk);
        chk("R8 wdt_rst one cycle", {31'b0, wdt_rst}, 32'd0);
        repeat (5) @(negedge clk);
        rd(4'h0, v);
        chk("R9 cause sticky", v, 32'hD);
        wr(4'h0, 32'h0);
        rd(4'h0, v);
        chk("R9 writing zero keeps flags", v, 32'hD);
        wr(4'h0, 32'h8);
        rd(4'h0, v);
        chk("R9 clear cause only", v, 32'h5);
        wr(4'h0, 32'h4);
        rd(4'h0, v);
        chk("R9 clear warn", v, 32'h1);
        wr(4'h4, 32'h0);
        rd(4'h0, v);
        chk("R4 stopped", v, 32'h0);

        // R10: service between the expiries.
        wr(4'h0, 32'h2);
        e0 = cyc;
        r0 = rst_seen;
        wait_evt(3 * IV);
        chk("R5 expiry with arm_a", cyc - e0, IV);
        chk("R6 irq with arm_a", {31'b0, irq}, 32'd1);
        wr(4'h0, 32'h6);
        rd(4'h0, v);
        chk("R10 service clears warn", v, 32'h2);
        wait_evt(3 * IV);
        chk("R10 warn again, not reset", {31'b0, irq}, 32'd1);
        chk("R10 next expiry edge", cyc - e0, 2 * IV);
        chk("R10 no reset pulse", rst_seen - r0, 0);
        wr(4'h0, 32'h0);
        rd(4'h0, v);
        chk("R4 lone arm_a clears directly", v, 32'h4);
        wr(4'h0, 32'h4);
        rd(4'h0, v);
        chk("R9 warn cleared", v, 32'h0);

        // R5: idle watchdog stays quiet.
        i0 = irq_seen;
        r0 = rst_seen;
        repeat (3 * IV) @(negedge clk);
        chk("R5 idle no irq", irq_seen - i0, 0);
        chk("R5 idle no reset", rst_seen - r0, 0);

        // R9: service on the expiry edge loses to the expiry.
        wr(4'h0, 32'h2);
        e0 = cyc;
        while (cyc != e0 + IV - 1) @(negedge clk);
        wr(4'h0, 32'h6);
        chk("R9 expiry wins race, irq", {31'b0, irq}, 32'd1);
        rd(4'h0, v);
        chk("R9 expiry wins race, warn", v, 32'h6);

        // R11: reset in the middle of operation.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(4'h0, v);
        chk("R11 word A cleared", v, 32'h0);
        rd(4'h4, v);
        chk("R11 word B cleared", v, 32'h0);
        chk("R11 outputs low", {30'b0, irq, wdt_rst}, 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule